// File: doc/BRIEF.md
# Fractional baud tick generator

This block derives the timing strobes of a serial transmitter and receiver from the module clock. Software programs an integer divisor and a fine adjustment in 1/32 steps through a byte-wide register port. The block then emits a one-cycle sample strobe at sixteen times the bit rate, and a bit strobe on every sixteenth sample strobe.

The integer divisor is 13 bits wide. Its upper part is held in a high byte and its lower part in a low byte. The fraction sits in a separate fine-adjust byte. A small phase accumulator takes the fraction once per divider wrap. Each carry out of the accumulator lengthens the following sample period by one clock. The mean sample period is therefore exactly the divisor plus fraction/32 clocks, and the bit rate is clk / (16 × (divisor + fraction/32)). A divisor of zero stops the strobes.

A new divisor is applied only when the low byte is written. Software therefore writes the fine-adjust byte, then the high byte, then the low byte. No half-updated value ever drives the counter.

Top module: `fracbaud_gen`

## Requirements
- R1: After reset, registers 0, 1 and 2 read 0x00, and no sample or bit strobe appears.
- R2: Register map (2-bit address):
  - 0 is the high byte: bits [4:0] hold divisor bits [12:8], and bits [7:5] are stored but have no effect on timing.
  - 1 is the low byte, holding divisor bits [7:0].
  - 2 is the fine-adjust byte: bits [4:0] hold the fraction, and bits [7:5] are stored only.
  - 3 reads 0x00.
  - Every stored byte reads back exactly as written.
- R3: Writing the high byte alone leaves the strobe spacing unchanged. The divisor in use changes only on a write to the low byte, which loads the high byte's stored bits [4:0] together with the written low byte.
- R4: With fraction 0 and divisor N ≥ 2, consecutive sample strobes are exactly N clocks apart.
- R5: With fraction F, each sample period is N or N+1 clocks. A 5-bit accumulator adds F on every wrap, and a carry lengthens the next period by one clock. Any 32 consecutive periods counted from a low-byte write total exactly 32·N+F clocks.
- R6: A low-byte write restarts the divider, the accumulator and the strobe-of-sixteen counter. Counting sample strobes from 1 after that write, bit_tick is high together with the sample strobes numbered 16, 32, …, and at no other time.
- R7: While the divisor in use is 0, no strobe is produced and the accumulator stays at zero.
- R8: For divisors of 2 or more, each sample strobe is high for exactly one clock.
- R9: With divisor 1, fraction 0 gives a strobe on every clock. A nonzero fraction gives periods of 1 or 2 clocks that follow R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| sample_tick | output | 1 | One-cycle strobe at sixteen times the bit rate |
| bit_tick | output | 1 | One-cycle strobe on every sixteenth sample strobe |

## Verification
The bench measures the spacing between sample strobes and compares it, period by period, with a sequence derived from the accumulator rule. It also checks that 32 periods total 32·N+F clocks. A design that applied the carry to the wrong period, or dropped the fraction, would fail either the period-by-period comparison or the total.

The bench writes the high byte on its own and confirms that the spacing stays put. A design that applied the half-written divisor would shift to a period of about 261 clocks.

A divisor of 1 checks the shortest possible periods. A divisor of 0 must go silent. The flag bits are set in the high and fine-adjust bytes, and must read back unchanged while leaving the timing alone.

The bit strobe is counted from the restart. A divider that does not restart its sub-counter on a low-byte write would put the bit strobe off its sixteenth sample.

// File: rtl/fracbaud_pkg.sv
package fracbaud_pkg;
   typedef enum logic [1:0] {
      REG_DIV_HI = 2'd0,
      REG_DIV_LO = 2'd1,
      REG_FINE   = 2'd2,
      REG_SPARE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/fracbaud_regs.sv
module fracbaud_regs
   import fracbaud_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int INT_W  = 13,
   parameter int FRAC_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [INT_W-1:0]  act_div,
   output logic [FRAC_W-1:0] frac,
   output logic              reload
);
   localparam int HI_W = INT_W - DATA_W;

   logic [DATA_W-1:0] hi_q, lo_q, fine_q;
   logic [INT_W-1:0]  div_q;
   logic [INT_W-1:0]  div_new;
   reg_sel_e          sel;

   assign sel    = reg_sel_e'(addr);
   assign reload = we && (sel == REG_DIV_LO);

   generate
      if (HI_W > 0) begin : g_split
         assign div_new = {hi_q[HI_W-1:0], wdata};
      end else begin : g_narrow
         assign div_new = wdata[INT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         fine_q <= '0;
         div_q  <= '0;
      end else if (we) begin
         unique case (sel)
            REG_DIV_HI: hi_q <= wdata;
            REG_DIV_LO: begin
               lo_q  <= wdata;
               div_q <= div_new;
            end
            REG_FINE:   fine_q <= wdata;
            default:    ;
         endcase
      end
   end

   always_comb begin
      unique case (sel)
         REG_DIV_HI: rdata = hi_q;
         REG_DIV_LO: rdata = lo_q;
         REG_FINE:   rdata = fine_q;
         default:    rdata = '0;
      endcase
   end

   assign act_div = div_q;
   assign frac    = fine_q[FRAC_W-1:0];
endmodule

// File: rtl/fracbaud_core.sv
module fracbaud_core #(
   parameter int INT_W  = 13,
   parameter int FRAC_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic [INT_W-1:0]  div,
   input  logic [FRAC_W-1:0] frac,
   output logic              wrap,
   output logic [FRAC_W-1:0] acc
);
   localparam logic [INT_W-1:0] ONE = INT_W'(1);

   logic [INT_W-1:0]  cnt_q;
   logic [INT_W-1:0]  limit;
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   acc_sum;
   logic              stretch_q;
   logic              active;

   assign active  = |div;
   assign limit   = div - ONE + INT_W'(stretch_q);
   assign wrap    = active && (cnt_q == limit);
   assign acc_sum = {1'b0, acc_q} + {1'b0, frac};

   always_ff @(posedge clk) begin
      if (!rst_n || reload || !active) begin
         cnt_q     <= '0;
         acc_q     <= '0;
         stretch_q <= 1'b0;
      end else if (wrap) begin
         cnt_q     <= '0;
         acc_q     <= acc_sum[FRAC_W-1:0];
         stretch_q <= acc_sum[FRAC_W];
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign acc = acc_q;
endmodule

// File: rtl/fracbaud_ticks.sv
module fracbaud_ticks #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   input  logic wrap,
   output logic sample_tick,
   output logic bit_tick
);
   logic samp_q, bit_q;

   generate
      if (OVS == 1) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               samp_q <= 1'b0;
               bit_q  <= 1'b0;
            end else begin
               samp_q <= wrap;
               bit_q  <= wrap;
            end
         end
      end else begin : g_count
         localparam int OVS_W = $clog2(OVS);
         localparam logic [OVS_W-1:0] LAST = OVS_W'(OVS - 1);
         logic [OVS_W-1:0] ovs_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               samp_q <= 1'b0;
               bit_q  <= 1'b0;
               ovs_q  <= '0;
            end else begin
               samp_q <= wrap;
               bit_q  <= wrap && (ovs_q == LAST);
               if (reload)
                  ovs_q <= '0;
               else if (wrap)
                  ovs_q <= (ovs_q == LAST) ? '0 : ovs_q + OVS_W'(1);
            end
         end
      end
   endgenerate

   assign sample_tick = samp_q;
   assign bit_tick    = bit_q;
endmodule

// File: rtl/fracbaud_gen.sv
module fracbaud_gen #(
   parameter int DATA_W = 8,
   parameter int INT_W  = 13,
   parameter int FRAC_W = 5,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sample_tick,
   output logic              bit_tick
);
   generate
      if (INT_W < 2 || INT_W > 2 * DATA_W) begin : g_bad_int
         $error("INT_W must lie between 2 and twice DATA_W");
      end
      if (FRAC_W < 1 || FRAC_W > DATA_W) begin : g_bad_frac
         $error("FRAC_W must lie between 1 and DATA_W");
      end
      if (OVS < 1) begin : g_bad_ovs
         $error("OVS must be at least 1");
      end
   endgenerate

   logic [INT_W-1:0]  act_div;
   logic [FRAC_W-1:0] frac_w;
   logic [FRAC_W-1:0] acc_w;
   logic              reload_w;
   logic              wrap_w;

   fracbaud_regs #(.DATA_W(DATA_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .act_div (act_div),
      .frac    (frac_w),
      .reload  (reload_w)
   );

   fracbaud_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .reload (reload_w),
      .div    (act_div),
      .frac   (frac_w),
      .wrap   (wrap_w),
      .acc    (acc_w)
   );

   fracbaud_ticks #(.OVS(OVS)) u_ticks (
      .clk         (clk),
      .rst_n       (rst_n),
      .reload      (reload_w),
      .wrap        (wrap_w),
      .sample_tick (sample_tick),
      .bit_tick    (bit_tick)
   );
endmodule

// File: rtl/fracbaud_chk.sv
module fracbaud_chk #(
   parameter int INT_W  = 13,
   parameter int FRAC_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic [1:0]        addr,
   input logic              sample_tick,
   input logic              bit_tick,
   input logic [INT_W-1:0]  act_div,
   input logic [FRAC_W-1:0] acc
);
   AST_BIT_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick); // R6

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_tick && act_div > INT_W'(1)) |=> !sample_tick); // R8

   AST_IDLE_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (act_div == '0) |-> (acc == '0)); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (act_div == '0 && $past(act_div) == '0) |-> (!sample_tick && !bit_tick)); // R7

   AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == 2'd1) |=> $stable(act_div)); // R3
endmodule

bind fracbaud_gen fracbaud_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .we          (reg_we),
   .addr        (reg_addr),
   .sample_tick (sample_tick),
   .bit_tick    (bit_tick),
   .act_div     (act_div),
   .acc         (acc_w)
);

// File: tb/sim_fracbaud_gen.sv
module sim_fracbaud_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       sample_tick, bit_tick;

   fracbaud_gen u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sample_tick(sample_tick), .bit_tick(bit_tick)
   );

   always #2 clk = ~clk;

   int    checks = 0, errors = 0;
   int    cyc = 0, last = 0, have_last = 0;
   int    pops = 0, sum_iv = 0, nticks = 0;
   int    bit_errs = 0, width_errs = 0, cur_sbr = 0;
   bit    clr_req = 1'b0, prev_tick = 1'b0, done = 1'b0;
   string tag = "R4";
   int    expq[$];

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   // monitor: measures strobe spacing and pops the expected value
   always @(negedge clk) begin
      cyc++;
      if (clr_req) begin
         clr_req   = 1'b0;
         have_last = 0;
         pops      = 0;
         sum_iv    = 0;
         nticks    = 0;
         prev_tick = 1'b0;
      end else begin
         if (bit_tick && !sample_tick) bit_errs++;
         if (sample_tick) begin
            nticks++;
            if (bit_tick != ((nticks % 16) == 0)) bit_errs++;
            if (prev_tick && cur_sbr >= 2) width_errs++;
            if (have_last != 0 && expq.size() > 0) begin
               int e;
               e = expq.pop_front();
               chk((cyc - last) == e, tag, "sample period", cyc - last, e);
               pops++;
               sum_iv += cyc - last;
            end
            last      = cyc;
            have_last = 1;
         end
         prev_tick = sample_tick;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(posedge clk); #1;
      reg_addr = a; #1;
      v = int'(reg_rdata);
   endtask

   // driver: programs a setting and pushes the expected period sequence
   task automatic run_cfg(input logic [7:0] hi, input logic [7:0] lo,
                          input logic [7:0] fine, input string t);
      int acc, st, s, fr;
      wr(2'd2, fine);
      wr(2'd0, hi);
      wr(2'd1, lo);
      clr_req = 1'b1;
      cur_sbr = int'({hi[4:0], lo});
      fr      = int'(fine[4:0]);
      tag     = t;
      acc = 0; st = 0;
      s = acc + fr; st = (s >= 32) ? 1 : 0; acc = s % 32;
      for (int i = 0; i < 32; i++) begin
         expq.push_back(cur_sbr + st);
         s = acc + fr; st = (s >= 32) ? 1 : 0; acc = s % 32;
      end
      while (expq.size() > 0) @(negedge clk);
      chk(sum_iv == 32 * cur_sbr + fr, "R5", "sum of 32 periods",
          sum_iv, 32 * cur_sbr + fr);
   endtask

   initial begin
      int v;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      rd(2'd0, v); chk(v == 0, "R1", "high byte after reset", v, 0);
      rd(2'd1, v); chk(v == 0, "R1", "low byte after reset", v, 0);
      rd(2'd2, v); chk(v == 0, "R1", "fine byte after reset", v, 0);
      repeat (100) @(posedge clk);
      chk(nticks == 0, "R1", "strobes after reset", nticks, 0);

      run_cfg(8'h00, 8'd5, 8'h00, "R4");

      // half write: high byte alone must not alter the spacing
      wr(2'd0, 8'h01);
      rd(2'd0, v); chk(v == 8'h01, "R2", "high byte readback", v, 8'h01);
      tag = "R3";
      for (int i = 0; i < 32; i++) expq.push_back(5);
      while (expq.size() > 0) @(negedge clk);

      run_cfg(8'h01, 8'h02, 8'h01, "R5");
      run_cfg(8'h00, 8'd4, 8'h07, "R5");
      run_cfg(8'h00, 8'd3, 8'h1F, "R5");
      run_cfg(8'h00, 8'd1, 8'h00, "R9");
      run_cfg(8'h00, 8'd1, 8'h10, "R9");
      run_cfg(8'hE1, 8'h23, 8'hA9, "R2");
      rd(2'd0, v); chk(v == 8'hE1, "R2", "high byte with flags", v, 8'hE1);
      rd(2'd1, v); chk(v == 8'h23, "R2", "low byte", v, 8'h23);
      rd(2'd2, v); chk(v == 8'hA9, "R2", "fine byte with flags", v, 8'hA9);
      rd(2'd3, v); chk(v == 0, "R2", "spare address", v, 0);

      // zero divisor stops all strobes
      wr(2'd0, 8'hC0);
      wr(2'd1, 8'h00);
      clr_req = 1'b1;
      cur_sbr = 0;
      repeat (300) @(posedge clk);
      chk(nticks == 0, "R7", "strobes with zero divisor", nticks, 0);

      run_cfg(8'h00, 8'd6, 8'h03, "R5");

      chk(bit_errs == 0, "R6", "bit strobe misplacements", bit_errs, 0);
      chk(width_errs == 0, "R8", "wide sample strobes", width_errs, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule